// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Generator

This block turns processor-side memory requests into external bus cycles on a pin set where the low address byte and the data byte share one set of bidirectional lines. Each bus cycle lasts a fixed number of oscillator clocks, five by default. The cycle opens with an address strobe, during which the low address byte is driven onto the shared lines so that external logic can latch it. A data strobe follows, during which data moves in the direction given by the read/write line. The upper address bits have their own lines and stay steady for the whole cycle.

The processor side presents a full address, a write flag and write data whenever `take_o` is high. The block samples them at the next clock edge. Read data is captured at the edge where the data strobe falls and is returned with a one-clock valid pulse. Reads from the internal low address window take their data from the internal source, and whatever is on the external lines is ignored.

An idle request, sampled only at a cycle boundary, parks the pins in the low-power state used by the wait and stop modes. Both strobes are low, read/write is high and the shared lines are released. The upper address lines keep following the address of the next instruction.

Top module: `mxb_cycle_gen`

## Requirements
- R1: While `rst_ni` is low, `as_o`, `ds_o` and `b_oe_o` are 0, `rw_n_o` is 1 and `take_o` is 1.
- R2: In a running bus cycle of PHASES clocks (default 5), `as_o` is high for the first AS_PHASES clocks (default 2, phases 0–1) and `ds_o` is high for the remaining clocks (phases 2–4). The two are never high together.
- R3: While `as_o` is high, `b_oe_o` is 1 and `b_o` equals bits 7:0 of the sampled address.
- R4: `a_hi_o` equals bits 12:8 of the sampled address for the whole cycle. Changes on the request inputs during a cycle have no effect until the next sampling edge.
- R5: `rw_n_o` is 0 during every clock of a write cycle and 1 during every clock of a read cycle.
- R6: During the data strobe of a write, `b_oe_o` is 1 and `b_o` carries the sampled write data. If the next state is idle, the drive and the data are held for one more clock after `ds_o` falls.
- R7: During the data strobe of a read, `b_oe_o` is 0. `b_i` is captured at the clock edge where `ds_o` falls. For the one clock after that edge `rd_valid_o` is 1 and `rd_data_o` shows the captured byte. At all other times `rd_valid_o` is 0.
- R8: For a read whose address is below INT_LIMIT (default 128), `rd_data_o` takes `int_rdata_i` sampled at the capture edge, and `b_i` is ignored.
- R9: When `idle_i` is 1 at a sampling edge, the following clock shows `as_o` = 0, `ds_o` = 0, `rw_n_o` = 1 and `b_oe_o` = 0 (apart from the write hold of R6). `a_hi_o` equals bits 12:8 of `req_addr_i` as sampled at the previous edge. `idle_i` has no effect at other edges.
- R10: `take_o` is 1 in every idle clock and in the last phase of a running cycle, and 0 in all other clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | Request low-power idle at the next boundary |
| req_addr_i | input | 13 | Address of the next access |
| req_wr_i | input | 1 | 1 for a write, 0 for a read |
| req_wdata_i | input | 8 | Write data |
| take_o | output | 1 | Request inputs are sampled at the next edge |
| rd_data_o | output | 8 | Captured read data |
| rd_valid_o | output | 1 | One-clock pulse marking new read data |
| int_rdata_i | input | 8 | Read data from the internal window |
| as_o | output | 1 | Address strobe |
| ds_o | output | 1 | Data strobe |
| rw_n_o | output | 1 | High for read, low for write |
| a_hi_o | output | 5 | Non-multiplexed upper address |
| b_o | output | 8 | Shared address/data lines, output value |
| b_i | input | 8 | Shared address/data lines, input value |
| b_oe_o | output | 1 | Drive enable for the shared lines |

## Verification
The properties assume the requester offers a new request only when `take_o` is high, and that `b_i` and `int_rdata_i` only need to be valid at the capture edge. The properties check strobe exclusivity, drive direction and pin stability, and none of them depends on the request values. The stimulus changes the request and idle inputs freely inside a cycle to show that these values are ignored. It applies the real request at the clock where `take_o` is high. It presents the read sources only in the last data phase, mixing directed addresses on both sides of the internal window limit with random reads, writes and idle gaps.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

   // Which part of the bus cycle the pins are in
   typedef enum logic [1:0] {
      PIN_IDLE = 2'd0,
      PIN_ADDR = 2'd1,
      PIN_DATA = 2'd2
   } pin_phase_e;

   // Width of a counter that spans n states (at least one bit)
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mxb_phase_seq.sv
module mxb_phase_seq
   import mxb_pkg::*;
#(
   parameter int unsigned PHASES    = 5,
   parameter int unsigned AS_PHASES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       idle_i,
   output logic       take_o,
   output pin_phase_e pin_phase_o
);
   localparam int unsigned PW = cnt_bits(PHASES);
   localparam logic [PW-1:0] LAST_PH  = PW'(PHASES - 1);
   localparam logic [PW-1:0] ADDR_END = PW'(AS_PHASES);

   logic [PW-1:0] ph_q;
   logic          run_q;

   assign take_o = !run_q || (ph_q == LAST_PH);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         ph_q  <= '0;
      end else if (take_o) begin
         run_q <= !idle_i;
         ph_q  <= '0;
      end else begin
         ph_q  <= ph_q + 1'b1;
      end
   end

   always_comb begin
      if (!run_q)                pin_phase_o = PIN_IDLE;
      else if (ph_q < ADDR_END)  pin_phase_o = PIN_ADDR;
      else                       pin_phase_o = PIN_DATA;
   end

endmodule

// File: rtl/mxb_req_latch.sv
module mxb_req_latch #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              take_i,
   input  logic              idle_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic              req_wr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_o,
   output logic [DATA_W-1:0] wdata_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_o  <= '0;
         wr_o    <= 1'b0;
         wdata_o <= '0;
      end else if (take_i) begin
         // address follows the next access even while parked
         addr_o <= req_addr_i;
         wr_o   <= req_wr_i && !idle_i;
         // keep the last write byte through an idle entry for the hold clock
         if (!idle_i) wdata_o <= req_wdata_i;
      end
   end

endmodule

// File: rtl/mxb_pin_drive.sv
module mxb_pin_drive
   import mxb_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  pin_phase_e               pin_phase_i,
   input  logic                     take_i,
   input  logic                     idle_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic                     wr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic                     as_o,
   output logic                     ds_o,
   output logic                     rw_n_o,
   output logic [ADDR_W-DATA_W-1:0] a_hi_o,
   output logic [DATA_W-1:0]        b_o,
   output logic                     b_oe_o
);
   logic hold_q;

   // one extra drive clock after a write strobe when the bus parks next
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q <= 1'b0;
      else         hold_q <= take_i && idle_i && wr_i && (pin_phase_i == PIN_DATA);
   end

   always_comb begin
      as_o   = (pin_phase_i == PIN_ADDR);
      ds_o   = (pin_phase_i == PIN_DATA);
      rw_n_o = !(wr_i && (pin_phase_i != PIN_IDLE));
      a_hi_o = addr_i[ADDR_W-1:DATA_W];
      b_oe_o = as_o || (ds_o && wr_i) || hold_q;
      if (as_o)        b_o = addr_i[DATA_W-1:0];
      else if (b_oe_o) b_o = wdata_i;
      else             b_o = '0;
   end

endmodule

// File: rtl/mxb_rd_capture.sv
module mxb_rd_capture #(
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned INT_LIMIT = 128
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cap_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] int_rdata_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o
);
   logic is_int;

   generate
      if (INT_LIMIT > 0) begin : g_int_win
         assign is_int = (addr_i < ADDR_W'(INT_LIMIT));
      end else begin : g_no_int_win
         assign is_int = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_data_o  <= '0;
         rd_valid_o <= 1'b0;
      end else begin
         rd_valid_o <= cap_i;
         if (cap_i) rd_data_o <= is_int ? int_rdata_i : b_i;
      end
   end

endmodule

// File: rtl/mxb_cycle_gen.sv
module mxb_cycle_gen
   import mxb_pkg::*;
#(
   parameter int unsigned PHASES    = 5,
   parameter int unsigned AS_PHASES = 2,
   parameter int unsigned ADDR_W    = 13,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned INT_LIMIT = 128
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     idle_i,
   input  logic [ADDR_W-1:0]        req_addr_i,
   input  logic                     req_wr_i,
   input  logic [DATA_W-1:0]        req_wdata_i,
   output logic                     take_o,
   output logic [DATA_W-1:0]        rd_data_o,
   output logic                     rd_valid_o,
   input  logic [DATA_W-1:0]        int_rdata_i,
   output logic                     as_o,
   output logic                     ds_o,
   output logic                     rw_n_o,
   output logic [ADDR_W-DATA_W-1:0] a_hi_o,
   output logic [DATA_W-1:0]        b_o,
   input  logic [DATA_W-1:0]        b_i,
   output logic                     b_oe_o
);
   // elaboration-time parameter checks
   generate
      if (PHASES < 3) begin : g_bad_phases
         $error("PHASES must be at least 3");
      end
      if (AS_PHASES < 1 || AS_PHASES >= PHASES) begin : g_bad_as
         $error("AS_PHASES must leave at least one data phase");
      end
      if (ADDR_W <= DATA_W) begin : g_bad_addr
         $error("ADDR_W must exceed DATA_W");
      end
      if (INT_LIMIT >= (1 << ADDR_W)) begin : g_bad_int
         $error("INT_LIMIT must fit in the address space");
      end
   endgenerate

   pin_phase_e        pin_phase;
   logic              take;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_q;
   logic [DATA_W-1:0] wdata_q;

   assign take_o = take;

   mxb_phase_seq #(.PHASES(PHASES), .AS_PHASES(AS_PHASES)) seq_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .idle_i      (idle_i),
      .take_o      (take),
      .pin_phase_o (pin_phase)
   );

   mxb_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) req_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .take_i      (take),
      .idle_i      (idle_i),
      .req_addr_i  (req_addr_i),
      .req_wr_i    (req_wr_i),
      .req_wdata_i (req_wdata_i),
      .addr_o      (addr_q),
      .wr_o        (wr_q),
      .wdata_o     (wdata_q)
   );

   mxb_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_phase_i (pin_phase),
      .take_i      (take),
      .idle_i      (idle_i),
      .addr_i      (addr_q),
      .wr_i        (wr_q),
      .wdata_i     (wdata_q),
      .as_o        (as_o),
      .ds_o        (ds_o),
      .rw_n_o      (rw_n_o),
      .a_hi_o      (a_hi_o),
      .b_o         (b_o),
      .b_oe_o      (b_oe_o)
   );

   mxb_rd_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_LIMIT(INT_LIMIT)) cap_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cap_i       (take && !wr_q && (pin_phase == PIN_DATA)),
      .addr_i      (addr_q),
      .b_i         (b_i),
      .int_rdata_i (int_rdata_i),
      .rd_data_o   (rd_data_o),
      .rd_valid_o  (rd_valid_o)
   );

endmodule

// File: rtl/mxb_cycle_chk.sv
module mxb_cycle_chk #(
   parameter int unsigned HI_W = 5
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            take_o,
   input logic            rd_valid_o,
   input logic            as_o,
   input logic            ds_o,
   input logic            rw_n_o,
   input logic [HI_W-1:0] a_hi_o,
   input logic            b_oe_o
);
   assert_as_ds_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(as_o && ds_o));

   assert_addr_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      as_o |-> b_oe_o);

   assert_hi_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((as_o || ds_o) && !take_o) |=> $stable(a_hi_o));

   assert_rw_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((as_o || ds_o) && !take_o) |=> $stable(rw_n_o));

   assert_write_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ds_o && !rw_n_o) |-> b_oe_o);

   assert_read_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ds_o && rw_n_o) |-> !b_oe_o);

   assert_rd_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_valid_o |-> (!ds_o && $past(ds_o) && $past(rw_n_o)));

   assert_idle_rw_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!as_o && !ds_o) |-> rw_n_o);

   assert_take_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      as_o |-> !take_o);

endmodule

bind mxb_cycle_gen mxb_cycle_chk #(.HI_W(ADDR_W - DATA_W)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .take_o     (take_o),
   .rd_valid_o (rd_valid_o),
   .as_o       (as_o),
   .ds_o       (ds_o),
   .rw_n_o     (rw_n_o),
   .a_hi_o     (a_hi_o),
   .b_oe_o     (b_oe_o)
);

// File: tb/mxb_cycle_gen_tb_top.sv
module mxb_cycle_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        idle;
   logic [12:0] req_addr;
   logic        req_wr;
   logic [7:0]  req_wdata;
   logic        take;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic [7:0]  int_rdata;
   logic        as_s, ds_s, rw_n;
   logic [4:0]  a_hi;
   logic [7:0]  b_out, b_in;
   logic        b_oe;

   int checks = 0;
   int errors = 0;

   bit          pend_rd   = 0;
   logic [7:0]  pend_val  = '0;
   bit          pend_hold = 0;
   logic [7:0]  hold_val  = '0;
   logic [12:0] last_req  = '0;

   always #10 clk = ~clk;

   mxb_cycle_gen dut_i (
      .clk_i (clk), .rst_ni (rst_n), .idle_i (idle),
      .req_addr_i (req_addr), .req_wr_i (req_wr), .req_wdata_i (req_wdata),
      .take_o (take), .rd_data_o (rd_data), .rd_valid_o (rd_valid),
      .int_rdata_i (int_rdata), .as_o (as_s), .ds_o (ds_s), .rw_n_o (rw_n),
      .a_hi_o (a_hi), .b_o (b_out), .b_i (b_in), .b_oe_o (b_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit is_int(input logic [12:0] a);
      return a < 13'd128;
   endfunction

   function automatic bit exp_as(input int p);
      return p < 2;
   endfunction

   function automatic bit exp_oe(input int p, input bit wr);
      return (p < 2) || wr;
   endfunction

   // result of the previous cycle, seen one clock after the capture edge
   task automatic check_result();
      if (pend_rd) begin
         chk("R7 rd_valid after read", {31'd0, rd_valid}, 32'd1);
         chk(is_int(last_req) ? "R8 internal read data" : "R7 external read data",
             {24'd0, rd_data}, {24'd0, pend_val});
      end else begin
         chk("R7 rd_valid quiet", {31'd0, rd_valid}, 32'd0);
      end
      pend_rd = 0;
   endtask

   // entered at a negedge with take high; leaves at the last-phase negedge
   task automatic run_cycle(input logic [12:0] a, input bit wr, input logic [7:0] wd,
                            input bit scramble);
      chk("R10 take before cycle", {31'd0, take}, 32'd1);
      req_addr = a; req_wr = wr; req_wdata = wd; idle = 1'b0;
      @(posedge clk); @(negedge clk);
      last_req = a;
      check_result();
      pend_hold = 0;
      for (int p = 0; p < 5; p++) begin
         chk("R2 as phase", {31'd0, as_s}, {31'd0, exp_as(p)});
         chk("R2 ds phase", {31'd0, ds_s}, {31'd0, !exp_as(p)});
         chk("R4 a_hi", {27'd0, a_hi}, {27'd0, a[12:8]});
         chk("R5 rw_n", {31'd0, rw_n}, {31'd0, !wr});
         chk(p < 2 ? "R3 oe addr" : (wr ? "R6 oe write" : "R7 oe read"),
             {31'd0, b_oe}, {31'd0, exp_oe(p, wr)});
         if (p < 2) chk("R3 low address", {24'd0, b_out}, {24'd0, a[7:0]});
         else if (wr) chk("R6 write data", {24'd0, b_out}, {24'd0, wd});
         chk("R10 take phase", {31'd0, take}, {31'd0, p == 4});
         if (p < 4) begin
            if (scramble) begin
               idle = 1'($urandom); req_addr = 13'($urandom);
               req_wr = 1'($urandom); req_wdata = 8'($urandom);
            end
            @(posedge clk); @(negedge clk);
         end else begin
            b_in = 8'($urandom); int_rdata = 8'($urandom);
            pend_rd = !wr;
            pend_val = is_int(a) ? int_rdata : b_in;
            pend_hold = wr; hold_val = wd;
            idle = 1'b0;
         end
      end
   endtask

   task automatic idle_cycles(input int n);
      for (int k = 0; k < n; k++) begin
         logic [12:0] na;
         na = 13'($urandom);
         idle = 1'b1; req_addr = na; req_wr = 1'($urandom);
         @(posedge clk); @(negedge clk);
         check_result();
         chk("R9 idle as", {31'd0, as_s}, 32'd0);
         chk("R9 idle ds", {31'd0, ds_s}, 32'd0);
         chk("R9 idle rw_n", {31'd0, rw_n}, 32'd1);
         chk("R9 idle a_hi", {27'd0, a_hi}, {27'd0, na[12:8]});
         chk("R10 idle take", {31'd0, take}, 32'd1);
         if (pend_hold) begin
            chk("R6 write hold oe", {31'd0, b_oe}, 32'd1);
            chk("R6 write hold data", {24'd0, b_out}, {24'd0, hold_val});
         end else begin
            chk("R9 idle oe", {31'd0, b_oe}, 32'd0);
         end
         pend_hold = 0;
         last_req = na;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog actual hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; idle = 1'b1; req_addr = '0; req_wr = 1'b0; req_wdata = '0;
      b_in = '0; int_rdata = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset as", {31'd0, as_s}, 32'd0);
      chk("R1 reset ds", {31'd0, ds_s}, 32'd0);
      chk("R1 reset rw_n", {31'd0, rw_n}, 32'd1);
      chk("R1 reset oe", {31'd0, b_oe}, 32'd0);
      chk("R1 reset take", {31'd0, take}, 32'd1);
      rst_n = 1'b1;
      idle_cycles(2);

      // directed corners
      run_cycle(13'h1ABC, 1'b0, 8'h00, 1'b0);   // external read
      run_cycle(13'h0F55, 1'b1, 8'hA5, 1'b1);   // write, inputs scrambled mid-cycle
      run_cycle(13'h007F, 1'b0, 8'h00, 1'b1);   // top of internal window
      run_cycle(13'h0080, 1'b0, 8'h00, 1'b0);   // first external address
      run_cycle(13'h0000, 1'b0, 8'h00, 1'b0);   // bottom of internal window
      run_cycle(13'h1FFF, 1'b1, 8'h3C, 1'b0);   // write then park
      idle_cycles(3);
      run_cycle(13'h1234, 1'b0, 8'h00, 1'b0);   // read then park
      idle_cycles(1);

      // random mix
      for (int i = 0; i < 300; i++) begin
         logic [12:0] a;
         a = ($urandom_range(0, 3) == 0) ? 13'($urandom_range(0, 255)) : 13'($urandom);
         run_cycle(a, 1'($urandom), 8'($urandom), 1'($urandom));
         if ($urandom_range(0, 5) == 0) idle_cycles(int'($urandom_range(1, 3)));
      end
      idle_cycles(1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule